// File: doc/BRIEF.md
# Register Window Controller

This block holds the bookkeeping for a processor's rotating register windows: the current window index, the number of windows that can still be entered without spilling, the number that can be left without filling, the number of windows known to be clean, the number that belong to another address space, and a small configuration word that selects which trap vector to use for spills and fills. The number of windows is a parameter (3 to 32).

The core presents one request per cycle: enter a window, leave a window, return (leave a window after an alignment check on the jump target), or flush windows. The block decides whether the request traps and commits the new window state on the same clock edge as the trap report. The trap report gives the kind of trap and the 3-bit vector selector taken from the configuration word. Privileged code reloads any of the state registers through a single write port. The register file itself and the routing of traps to handlers are handled elsewhere.

Top module: `regwin_ctl`

## Requirements
- R1: After reset, cur_win = 0, save_avail = NWIN-2, rest_avail = 0, clean_avail = NWIN-1, foreign_cnt = 0, vec_cfg = 0, trap_valid = 0, trap_kind = 0 and trap_vec = 0.
- R2: An enter request (req_op = 0) with save_avail = 0 raises a spill trap and sets cur_win to (cur_win+2) mod NWIN, leaving both counts unchanged; the kind is 2 (foreign) with trap_vec = vec_cfg[5:3] when foreign_cnt is nonzero, otherwise 1 (local) with trap_vec = vec_cfg[2:0].
- R3: An enter request with save_avail nonzero and clean_avail equal to rest_avail raises a clean-window trap (kind 5), sets cur_win to (cur_win+1) mod NWIN and leaves both counts unchanged.
- R4: Any other enter request raises no trap, sets cur_win to (cur_win+1) mod NWIN, decrements save_avail and increments rest_avail, saturating at NWIN-1.
- R5: A leave request (req_op = 1) always sets cur_win to (cur_win-1+NWIN) mod NWIN; with rest_avail = 0 it raises a fill trap (kind 4 foreign / 3 local, vector chosen as in R2) and leaves the counts unchanged, otherwise save_avail increments (saturating at NWIN-1) and rest_avail decrements.
- R6: A return request (req_op = 2) with ret_addr_lo nonzero raises an alignment trap (kind 6) and changes no state; with ret_addr_lo = 0 it behaves exactly as a leave request.
- R7: A flush request (req_op = 3) changes no state; it raises a spill trap (kind and vector as in R2) exactly when save_avail equals NWIN-2, and no trap otherwise.
- R8: The trap outputs and the state updates appear together one clock edge after the request and last one cycle; with no trap, trap_valid = 0, trap_kind = 0 and trap_vec = 0.
- R9: With wr_en high and req_valid low, wr_data is loaded on the next edge into the register chosen by wr_sel (0 cur_win, 1 save_avail, 2 rest_avail, 3 clean_avail, 4 foreign_cnt, 5 vec_cfg, 6 and 7 nothing); values above NWIN-1 load as NWIN-1 into the count registers and cur_win; when req_valid is high the write is ignored.
- R10: Requests never change clean_avail, foreign_cnt or vec_cfg.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 enter, 1 leave, 2 return, 3 flush |
| ret_addr_lo | input | 2 | Low two bits of the return target address |
| wr_en | input | 1 | Privileged write strobe |
| wr_sel | input | 3 | Register selected for the write |
| wr_data | input | 6 | Write value |
| cur_win | output | $clog2(NWIN) | Current window index |
| save_avail | output | $clog2(NWIN) | Windows enterable without spill |
| rest_avail | output | $clog2(NWIN) | Windows leavable without fill |
| clean_avail | output | $clog2(NWIN) | Clean window count |
| foreign_cnt | output | $clog2(NWIN) | Windows owned by another space |
| vec_cfg | output | 6 | Spill/fill vector selector, [2:0] local, [5:3] foreign |
| trap_valid | output | 1 | Trap raised by the previous request |
| trap_kind | output | 3 | 0 none, 1/2 spill, 3/4 fill, 5 clean, 6 alignment |
| trap_vec | output | 3 | Vector selector for the spill or fill trap |

## Verification
Every result of a request, both the trap report and the committed window state, is due exactly one clock edge after the strobe, and every write is visible one edge after wr_en. The bench drives inputs on the falling edge and samples all outputs on the following falling edge, so exactly one rising edge separates stimulus and check; one cycle later still it confirms the trap report has dropped. A small five-window build is swept over nearly every combination of counts and pointer for each request type, with expected values computed arithmetically.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int VSEL_W = 3;
    localparam int CFG_W  = 2 * VSEL_W;

    typedef enum logic [1:0] {
        OP_ENTER  = 2'd0,
        OP_LEAVE  = 2'd1,
        OP_RETURN = 2'd2,
        OP_FLUSH  = 2'd3
    } win_op_e;

    typedef enum logic [2:0] {
        TK_NONE      = 3'd0,
        TK_SPILL_LOC = 3'd1,
        TK_SPILL_FGN = 3'd2,
        TK_FILL_LOC  = 3'd3,
        TK_FILL_FGN  = 3'd4,
        TK_CLEAN     = 3'd5,
        TK_ALIGN     = 3'd6
    } trap_kind_e;

    typedef enum logic [2:0] {
        SEL_CUR    = 3'd0,
        SEL_SAVE   = 3'd1,
        SEL_REST   = 3'd2,
        SEL_CLEAN  = 3'd3,
        SEL_FGN    = 3'd4,
        SEL_CFG    = 3'd5
    } wr_sel_e;

endpackage

// File: rtl/regwin_ring.sv
// Modular pointer arithmetic on the window ring.
module regwin_ring #(
    parameter int NWIN = 8,
    localparam int CNT_W = $clog2(NWIN)
) (
    input  logic [CNT_W-1:0] cur,
    output logic [CNT_W-1:0] fwd1,
    output logic [CNT_W-1:0] fwd2,
    output logic [CNT_W-1:0] back1
);
    localparam logic [CNT_W:0] N_X = (CNT_W+1)'(NWIN);

    logic [CNT_W:0] sum1;
    logic [CNT_W:0] sum2;

    always_comb begin
        sum1  = {1'b0, cur} + (CNT_W+1)'(1);
        sum2  = {1'b0, cur} + (CNT_W+1)'(2);
        fwd1  = (sum1 >= N_X) ? CNT_W'(sum1 - N_X) : CNT_W'(sum1);
        fwd2  = (sum2 >= N_X) ? CNT_W'(sum2 - N_X) : CNT_W'(sum2);
        back1 = (cur == '0) ? CNT_W'(NWIN - 1) : cur - CNT_W'(1);
    end
endmodule

// File: rtl/regwin_sat.sv
// Saturating step of a window count bounded to 0..NWIN-1.
module regwin_sat #(
    parameter int NWIN = 8,
    localparam int CNT_W = $clog2(NWIN)
) (
    input  logic [CNT_W-1:0] val,
    output logic [CNT_W-1:0] inc,
    output logic [CNT_W-1:0] dec
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(NWIN - 1);

    always_comb begin
        inc = (val >= TOP) ? TOP : val + CNT_W'(1);
        dec = (val == '0) ? '0 : val - CNT_W'(1);
    end
endmodule

// File: rtl/regwin_pick.sv
// Trap decision for one request; exactly one kind is produced.
module regwin_pick
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CNT_W = $clog2(NWIN)
) (
    input  win_op_e          op,
    input  logic [1:0]       addr_lo,
    input  logic [CNT_W-1:0] save_avail,
    input  logic [CNT_W-1:0] rest_avail,
    input  logic [CNT_W-1:0] clean_avail,
    input  logic [CNT_W-1:0] foreign_cnt,
    output trap_kind_e       kind
);
    localparam logic [CNT_W-1:0] FULL_SAVE = CNT_W'(NWIN - 2);

    logic fgn;

    always_comb begin
        fgn  = (foreign_cnt != '0);
        kind = TK_NONE;
        case (op)
            OP_ENTER: begin
                if (save_avail == '0)
                    kind = fgn ? TK_SPILL_FGN : TK_SPILL_LOC;
                else if (clean_avail == rest_avail)
                    kind = TK_CLEAN;
            end
            OP_LEAVE: begin
                if (rest_avail == '0)
                    kind = fgn ? TK_FILL_FGN : TK_FILL_LOC;
            end
            OP_RETURN: begin
                if (addr_lo != 2'b00)
                    kind = TK_ALIGN;
                else if (rest_avail == '0)
                    kind = fgn ? TK_FILL_FGN : TK_FILL_LOC;
            end
            default: begin
                if (save_avail == FULL_SAVE)
                    kind = fgn ? TK_SPILL_FGN : TK_SPILL_LOC;
            end
        endcase
    end
endmodule

// File: rtl/regwin_ctl.sv
module regwin_ctl
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CNT_W = $clog2(NWIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_op,
    input  logic [1:0]         ret_addr_lo,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [CFG_W-1:0]   wr_data,
    output logic [CNT_W-1:0]   cur_win,
    output logic [CNT_W-1:0]   save_avail,
    output logic [CNT_W-1:0]   rest_avail,
    output logic [CNT_W-1:0]   clean_avail,
    output logic [CNT_W-1:0]   foreign_cnt,
    output logic [CFG_W-1:0]   vec_cfg,
    output logic               trap_valid,
    output logic [2:0]         trap_kind,
    output logic [VSEL_W-1:0]  trap_vec
);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(NWIN - 1);
    localparam logic [CFG_W-1:0] WIDE_TOP = CFG_W'(NWIN - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cur;
        logic [CNT_W-1:0]  save;
        logic [CNT_W-1:0]  rest;
        logic [CNT_W-1:0]  clean;
        logic [CNT_W-1:0]  fgn;
        logic [CFG_W-1:0]  cfg;
        logic              tv;
        trap_kind_e        tk;
        logic [VSEL_W-1:0] tvec;
    } win_state_t;

    win_state_t st_d, st_q;

    win_op_e    op_w;
    trap_kind_e kind_w;
    logic [CNT_W-1:0] cur_f1, cur_f2, cur_b1;
    logic [CNT_W-1:0] sat_in  [2];
    logic [CNT_W-1:0] sat_inc [2];
    logic [CNT_W-1:0] sat_dec [2];

    assign op_w = win_op_e'(req_op);

    regwin_ring #(.NWIN(NWIN)) u_ring (
        .cur   (st_q.cur),
        .fwd1  (cur_f1),
        .fwd2  (cur_f2),
        .back1 (cur_b1)
    );

    assign sat_in[0] = st_q.save;
    assign sat_in[1] = st_q.rest;

    for (genvar g = 0; g < 2; g++) begin : g_sat
        regwin_sat #(.NWIN(NWIN)) u_sat (
            .val (sat_in[g]),
            .inc (sat_inc[g]),
            .dec (sat_dec[g])
        );
    end

    regwin_pick #(.NWIN(NWIN)) u_pick (
        .op          (op_w),
        .addr_lo     (ret_addr_lo),
        .save_avail  (st_q.save),
        .rest_avail  (st_q.rest),
        .clean_avail (st_q.clean),
        .foreign_cnt (st_q.fgn),
        .kind        (kind_w)
    );

    function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CFG_W-1:0] v);
        if (v > WIDE_TOP)
            return CNT_TOP;
        return v[CNT_W-1:0];
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.tv   = 1'b0;
        st_d.tk   = TK_NONE;
        st_d.tvec = '0;

        if (req_valid) begin
            st_d.tk = kind_w;
            st_d.tv = (kind_w != TK_NONE);
            case (kind_w)
                TK_SPILL_FGN, TK_FILL_FGN: st_d.tvec = st_q.cfg[CFG_W-1:VSEL_W];
                TK_SPILL_LOC, TK_FILL_LOC: st_d.tvec = st_q.cfg[VSEL_W-1:0];
                default:                   st_d.tvec = '0;
            endcase

            case (op_w)
                OP_ENTER: begin
                    if (kind_w == TK_SPILL_FGN || kind_w == TK_SPILL_LOC) begin
                        st_d.cur = cur_f2;
                    end else if (kind_w == TK_CLEAN) begin
                        st_d.cur = cur_f1;
                    end else begin
                        st_d.cur  = cur_f1;
                        st_d.save = sat_dec[0];
                        st_d.rest = sat_inc[1];
                    end
                end
                OP_LEAVE, OP_RETURN: begin
                    if (kind_w != TK_ALIGN) begin
                        st_d.cur = cur_b1;
                        if (kind_w == TK_NONE) begin
                            st_d.save = sat_inc[0];
                            st_d.rest = sat_dec[1];
                        end
                    end
                end
                default: begin
                end
            endcase
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CUR:   st_d.cur   = clamp_cnt(wr_data);
                SEL_SAVE:  st_d.save  = clamp_cnt(wr_data);
                SEL_REST:  st_d.rest  = clamp_cnt(wr_data);
                SEL_CLEAN: st_d.clean = clamp_cnt(wr_data);
                SEL_FGN:   st_d.fgn   = clamp_cnt(wr_data);
                SEL_CFG:   st_d.cfg   = wr_data;
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cur   <= '0;
            st_q.save  <= CNT_W'(NWIN - 2);
            st_q.rest  <= '0;
            st_q.clean <= CNT_TOP;
            st_q.fgn   <= '0;
            st_q.cfg   <= '0;
            st_q.tv    <= 1'b0;
            st_q.tk    <= TK_NONE;
            st_q.tvec  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_win     = st_q.cur;
    assign save_avail  = st_q.save;
    assign rest_avail  = st_q.rest;
    assign clean_avail = st_q.clean;
    assign foreign_cnt = st_q.fgn;
    assign vec_cfg     = st_q.cfg;
    assign trap_valid  = st_q.tv;
    assign trap_kind   = st_q.tk;
    assign trap_vec    = st_q.tvec;

endmodule

// File: rtl/regwin_ctl_chk.sv
module regwin_ctl_chk
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CNT_W = $clog2(NWIN)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [1:0]         req_op,
    input logic [1:0]         ret_addr_lo,
    input logic [CNT_W-1:0]   cur_win,
    input logic [CNT_W-1:0]   save_avail,
    input logic [CNT_W-1:0]   rest_avail,
    input logic [CNT_W-1:0]   clean_avail,
    input logic [CNT_W-1:0]   foreign_cnt,
    input logic [CFG_W-1:0]   vec_cfg,
    input logic               trap_valid,
    input logic [2:0]         trap_kind,
    input logic [VSEL_W-1:0]  trap_vec
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(NWIN - 1);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cur_win <= TOP && save_avail <= TOP && rest_avail <= TOP) // R9
        else $error("count out of range");

    AST_QUIET_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |-> (trap_kind == 3'd0 && trap_vec == '0)) // R8
        else $error("trap fields set without trap");

    AST_NO_REQ_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !trap_valid) // R8
        else $error("trap without request");

    AST_SPILL_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_ENTER && save_avail == '0) |=>
        (trap_valid && cur_win == CNT_W'((int'($past(cur_win)) + 2) % NWIN))) // R2
        else $error("spill pointer step wrong");

    AST_LEAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_LEAVE) |=>
        (cur_win == CNT_W'((int'($past(cur_win)) + NWIN - 1) % NWIN))) // R5
        else $error("leave pointer step wrong");

    AST_ALIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_RETURN && ret_addr_lo != 2'b00) |=>
        (trap_kind == TK_ALIGN && $stable(cur_win) && $stable(save_avail) && $stable(rest_avail))) // R6
        else $error("misaligned return altered state");

    AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_FLUSH) |=>
        ($stable(cur_win) && $stable(save_avail) && $stable(rest_avail))) // R7
        else $error("flush altered state");

    AST_SIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ($stable(clean_avail) && $stable(foreign_cnt) && $stable(vec_cfg))) // R10
        else $error("request altered side registers");

endmodule

bind regwin_ctl regwin_ctl_chk #(.NWIN(NWIN)) u_regwin_chk (.*);

// File: tb/tb_regwin_ctl.sv
module tb_regwin_ctl;
    localparam int CLK_P = 10;
    localparam int NW    = 5;
    localparam int CW    = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [1:0]    ret_addr_lo = '0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [5:0]    wr_data = '0;
    logic [CW-1:0] cur_win, save_avail, rest_avail, clean_avail, foreign_cnt;
    logic [5:0]    vec_cfg;
    logic          trap_valid;
    logic [2:0]    trap_kind;
    logic [2:0]    trap_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    regwin_ctl #(.NWIN(NW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .ret_addr_lo(ret_addr_lo), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cur_win(cur_win), .save_avail(save_avail), .rest_avail(rest_avail),
        .clean_avail(clean_avail), .foreign_cnt(foreign_cnt), .vec_cfg(vec_cfg),
        .trap_valid(trap_valid), .trap_kind(trap_kind), .trap_vec(trap_vec)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic write_reg(input int sel, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 6'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input int c, input int s, input int r, input int cl, input int f, input int cfg);
        write_reg(0, c); write_reg(1, s); write_reg(2, r);
        write_reg(3, cl); write_reg(4, f); write_reg(5, cfg);
    endtask

    // Drive one request and check its results one edge later (R2..R8, R10).
    task automatic run_op(input string tag, input int op, input int alo,
                          input int c, input int s, input int r, input int cl,
                          input int f, input int cfg);
        int ec, es, er, ek, ev;
        bit fg;
        ec = c; es = s; er = r; ek = 0; ev = 0;
        fg = (f != 0);
        case (op)
            0: begin
                if (s == 0) begin
                    ek = fg ? 2 : 1; ec = (c + 2) % NW;
                end else if (cl == r) begin
                    ek = 5; ec = (c + 1) % NW;
                end else begin
                    ec = (c + 1) % NW; es = s - 1; er = (r + 1 > NW - 1) ? NW - 1 : r + 1;
                end
            end
            1, 2: begin
                if (op == 2 && alo != 0) begin
                    ek = 6;
                end else begin
                    ec = (c + NW - 1) % NW;
                    if (r == 0) ek = fg ? 4 : 3;
                    else begin
                        es = (s + 1 > NW - 1) ? NW - 1 : s + 1; er = r - 1;
                    end
                end
            end
            default: begin
                if (s == NW - 2) ek = fg ? 2 : 1;
            end
        endcase
        if (ek >= 1 && ek <= 4) ev = fg ? ((cfg >> 3) & 7) : (cfg & 7);

        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); ret_addr_lo = 2'(alo);
        @(negedge clk);
        req_valid = 1'b0; ret_addr_lo = '0;
        check(tag, "cur_win", int'(cur_win), ec);
        check(tag, "save_avail", int'(save_avail), es);
        check(tag, "rest_avail", int'(rest_avail), er);
        check(tag, "trap_valid", int'(trap_valid), (ek != 0) ? 1 : 0);
        check(tag, "trap_kind", int'(trap_kind), ek);
        check(tag, "trap_vec", int'(trap_vec), ev);
        check("R10", "clean_avail", int'(clean_avail), cl);
        check("R10", "foreign_cnt", int'(foreign_cnt), f);
        check("R10", "vec_cfg", int'(vec_cfg), cfg);
        @(negedge clk);
        check("R8", "trap_valid drop", int'(trap_valid), 0);
        check("R8", "trap_kind drop", int'(trap_kind), 0);
    endtask

    initial begin : watchdog
        #(CLK_P * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL ALL watchdog expired: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int cwps[3];
        cwps[0] = 0; cwps[1] = 3; cwps[2] = 4;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "cur_win", int'(cur_win), 0);
        check("R1", "save_avail", int'(save_avail), NW - 2);
        check("R1", "rest_avail", int'(rest_avail), 0);
        check("R1", "clean_avail", int'(clean_avail), NW - 1);
        check("R1", "foreign_cnt", int'(foreign_cnt), 0);
        check("R1", "vec_cfg", int'(vec_cfg), 0);
        check("R1", "trap_valid", int'(trap_valid), 0);
        check("R1", "trap_kind", int'(trap_kind), 0);
        check("R1", "trap_vec", int'(trap_vec), 0);

        // R9 write port: loads, clamping, unused selects, collision with request
        write_reg(0, 31);
        check("R9", "cur_win clamp", int'(cur_win), NW - 1);
        write_reg(1, 2);
        check("R9", "save_avail load", int'(save_avail), 2);
        write_reg(5, 6'h2A);
        check("R9", "vec_cfg load", int'(vec_cfg), 6'h2A);
        write_reg(6, 1);
        check("R9", "sel 6 ignored cur", int'(cur_win), NW - 1);
        check("R9", "sel 6 ignored save", int'(save_avail), 2);
        write_reg(3, 4);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; wr_en = 1'b1; wr_sel = 3'd3; wr_data = 6'd1;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        check("R9", "write ignored during request", int'(clean_avail), 4);

        // Sweep: every request type over most state combinations
        for (int ci = 0; ci < 3; ci++)
            for (int s = 0; s < NW; s++)
                for (int r = 0; r < NW; r++)
                    for (int cl = 0; cl < NW; cl++)
                        for (int fi = 0; fi < 2; fi++) begin
                            int c, f, cfg, alo;
                            c = cwps[ci]; f = fi * 2;
                            cfg = ((7 - cl) << 3) | cl;
                            alo = ((s + r) % 3) + 1;
                            load(c, s, r, cl, f, cfg);
                            check("R9", "load cur_win", int'(cur_win), c);
                            run_op((s == 0) ? "R2" : ((cl == r) ? "R3" : "R4"), 0, 0, c, s, r, cl, f, cfg);
                            load(c, s, r, cl, f, cfg);
                            run_op("R5", 1, 0, c, s, r, cl, f, cfg);
                            load(c, s, r, cl, f, cfg);
                            run_op("R6", 2, 0, c, s, r, cl, f, cfg);
                            load(c, s, r, cl, f, cfg);
                            run_op("R6", 2, alo, c, s, r, cl, f, cfg);
                            load(c, s, r, cl, f, cfg);
                            run_op("R7", 3, 0, c, s, r, cl, f, cfg);
                        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule